// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a display panel's timing-generator chip up and down by issuing an ordered list of register writes with timed pauses between them. A power-up request carries a resolution mode and two stored calibration values (phase trim and common-electrode bias). The first power-up after reset or after a power-down runs the complete supply ordering. Later power-up requests only reprogram the phase and resolution registers. A power-down request waits for the panel to finish scanning, then turns the rails off in reverse order and parks the bias DAC at zero.

Register writes leave on a valid/ready address/data port. The bias level goes out on a second valid/ready port to a bit-serial DAC writer. The block reports `busy` while a sequence runs and pulses `done` when the last write has been taken. An `inited` flag tracks whether the panel is powered. Requests that arrive during a sequence are latched and served once the block is idle again.

Top module: `lcd_power_seq`

## Requirements
- R1: A power-up request with `inited` low produces these transfers in this order, as (address, data) writes: (6,1F) (3,03) (4,00) (4,04) [rail pause] (3,07) (6,09) bias transfer with base 0x04 (3,17) (4,06) [gate pause] (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00) [settle pause] (0,resolution).
- R2: The bias level sent during power-up is 125 when `bias_cal` is negative (bit 8 set), and otherwise `bias_cal[7:0]`.
- R3: When `up_mode` is 480 or 640, the phase byte is `{phase_cal[3:0],1}`, or 0x01 if `phase_cal` is negative (bit 7 set). For any other mode it is 0x13.
- R4: The resolution byte is 0x00 for modes 480 and 640 and 0x01 for every other mode. It is the final write of every power-up request.
- R5: A power-up request with `inited` high writes only (1,phase) and then (0,resolution). A completed full power-up sets `inited`.
- R6: A power-down request produces [frame pause] (4,06) (6,08) (3,14) bias transfer of level 0 with base 0x14 (4,04) (3,04) (6,1E) (3,00) (4,00), and then clears `inited`.
- R7: Each pause lasts at least its parameter in clock cycles: rail `T_RAIL_CYC`, gate `T_GATE_CYC`, settle `T_SETTLE_CYC`, frame `T_FRAME_CYC`. The frame pause is counted from the power-down request.
- R8: While `wr_valid` or `ser_valid` is high without its ready, the transfer's address/data or base/level stay unchanged. The two valid outputs are never high together.
- R9: `busy` rises within two cycles of a request and stays high until the final write is accepted. `done` is then high for exactly one cycle while `busy` is low.
- R10: A request received during a sequence is held and run after it. When both kinds are pending, the power-down runs first.
- R11: After reset, `busy`, `done`, `inited`, `wr_valid` and `ser_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Power-up request pulse |
| up_mode | input | MODE_W | Resolution mode (line count) sampled with `up_req` |
| phase_cal | input | 8 | Signed stored phase trim, sampled with `up_req` |
| bias_cal | input | 9 | Signed stored bias level, sampled with `up_req` |
| down_req | input | 1 | Power-down request pulse |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| ser_valid | output | 1 | Bias transfer offered |
| ser_ready | input | 1 | Bias transfer taken |
| ser_base | output | 8 | Power-register base bits held during the serial transfer |
| ser_level | output | 8 | Bias level to send |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| inited | output | 1 | Panel is powered |

## Verification
The main flow is tried with six calibration and mode vectors. Modes 640 and 480 are set against 320, 240 and an unlisted mode 100, which separates the two phase and resolution rules. A negative phase trim and a negative bias are compared with positive ones that have upper bits set, so the default values and the nibble masking can both be seen. Half the vectors toggle the ready inputs every cycle, which separates the order of the writes from handshake timing. Each vector runs a full power-up, a short re-entry and a power-down. Directed runs then send a power-up in the middle of a power-down, and both requests in the same cycle, which shows whether requests are held and which one runs first.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [1:0] {
        ST_WR,
        ST_WAIT,
        ST_SER
    } step_kind_e;

    typedef enum logic [1:0] {
        SQ_FULL,
        SQ_SHORT,
        SQ_DOWN
    } seq_e;

    typedef enum logic [1:0] {
        DL_RAIL,
        DL_GATE,
        DL_SETTLE,
        DL_FRAME
    } delay_e;

    typedef struct packed {
        step_kind_e kind;
        logic [7:0] addr;
        logic [7:0] data;
        delay_e     dly;
        logic       last;
    } step_t;

    // register addresses decoded by the timing-generator chip
    localparam logic [7:0] A_RES   = 8'h00;
    localparam logic [7:0] A_PHASE = 8'h01;
    localparam logic [7:0] A_PWR0  = 8'h03;
    localparam logic [7:0] A_PWR1  = 8'h04;
    localparam logic [7:0] A_CTRL  = 8'h06;
    localparam logic [7:0] A_POL   = 8'h07;

    localparam logic [7:0] BIAS_DEFAULT = 8'd125;
    localparam logic [7:0] PHASE_QVGA   = 8'h13;

    function automatic step_t mk_wr(input logic [7:0] a, input logic [7:0] d, input logic last);
        step_t s;
        s.kind = ST_WR;
        s.addr = a;
        s.data = d;
        s.dly  = DL_RAIL;
        s.last = last;
        return s;
    endfunction

    function automatic step_t mk_wait(input delay_e dl);
        step_t s;
        s.kind = ST_WAIT;
        s.addr = 8'h00;
        s.data = 8'h00;
        s.dly  = dl;
        s.last = 1'b0;
        return s;
    endfunction

    function automatic step_t mk_ser(input logic [7:0] base, input logic [7:0] lvl);
        step_t s;
        s.kind = ST_SER;
        s.addr = base;
        s.data = lvl;
        s.dly  = DL_RAIL;
        s.last = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/lcdseq_cal.sv
module lcdseq_cal #(
    parameter int MODE_W = 10
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [7:0]        phase_cal,
    input  logic [8:0]        bias_cal,
    output logic [7:0]        phase_val,
    output logic [7:0]        res_val,
    output logic [7:0]        bias_val
);
    import lcdseq_pkg::*;

    logic is_vga;
    logic unused_bits;

    assign unused_bits = ^phase_cal[6:4];

    always_comb begin
        is_vga = (mode == MODE_W'(480)) || (mode == MODE_W'(640));

        if (!is_vga) begin
            phase_val = PHASE_QVGA;
        end else if (phase_cal[7]) begin
            phase_val = 8'h01;
        end else begin
            phase_val = {3'b000, phase_cal[3:0], 1'b1};
        end

        res_val  = is_vga ? 8'h00 : 8'h01;
        bias_val = bias_cal[8] ? BIAS_DEFAULT : bias_cal[7:0];
    end

endmodule

// File: rtl/lcdseq_rom.sv
module lcdseq_rom (
    input  lcdseq_pkg::seq_e  seq,
    input  logic [4:0]        idx,
    input  logic [7:0]        phase_val,
    input  logic [7:0]        res_val,
    input  logic [7:0]        bias_val,
    output lcdseq_pkg::step_t step
);
    import lcdseq_pkg::*;

    always_comb begin
        step = mk_wr(A_RES, res_val, 1'b1);
        unique case (seq)
            SQ_FULL: begin
                unique case (idx)
                    5'd0:  step = mk_wr(A_CTRL, 8'h1F, 1'b0);
                    5'd1:  step = mk_wr(A_PWR0, 8'h03, 1'b0);
                    5'd2:  step = mk_wr(A_PWR1, 8'h00, 1'b0);
                    5'd3:  step = mk_wr(A_PWR1, 8'h04, 1'b0);
                    5'd4:  step = mk_wait(DL_RAIL);
                    5'd5:  step = mk_wr(A_PWR0, 8'h07, 1'b0);
                    5'd6:  step = mk_wr(A_CTRL, 8'h09, 1'b0);
                    5'd7:  step = mk_ser(8'h04, bias_val);
                    5'd8:  step = mk_wr(A_PWR0, 8'h17, 1'b0);
                    5'd9:  step = mk_wr(A_PWR1, 8'h06, 1'b0);
                    5'd10: step = mk_wait(DL_GATE);
                    5'd11: step = mk_wr(A_CTRL, 8'h01, 1'b0);
                    5'd12: step = mk_wr(A_PWR0, 8'h1F, 1'b0);
                    5'd13: step = mk_wr(A_PWR1, 8'h07, 1'b0);
                    5'd14: step = mk_wr(A_CTRL, 8'h00, 1'b0);
                    5'd15: step = mk_wr(A_PHASE, phase_val, 1'b0);
                    5'd16: step = mk_wr(A_POL, 8'h00, 1'b0);
                    5'd17: step = mk_wait(DL_SETTLE);
                    default: step = mk_wr(A_RES, res_val, 1'b1);
                endcase
            end
            SQ_SHORT: begin
                if (idx == 5'd0) step = mk_wr(A_PHASE, phase_val, 1'b0);
                else             step = mk_wr(A_RES, res_val, 1'b1);
            end
            SQ_DOWN: begin
                unique case (idx)
                    5'd0:  step = mk_wait(DL_FRAME);
                    5'd1:  step = mk_wr(A_PWR1, 8'h06, 1'b0);
                    5'd2:  step = mk_wr(A_CTRL, 8'h08, 1'b0);
                    5'd3:  step = mk_wr(A_PWR0, 8'h14, 1'b0);
                    5'd4:  step = mk_ser(8'h14, 8'h00);
                    5'd5:  step = mk_wr(A_PWR1, 8'h04, 1'b0);
                    5'd6:  step = mk_wr(A_PWR0, 8'h04, 1'b0);
                    5'd7:  step = mk_wr(A_CTRL, 8'h1E, 1'b0);
                    5'd8:  step = mk_wr(A_PWR0, 8'h00, 1'b0);
                    default: step = mk_wr(A_PWR1, 8'h00, 1'b1);
                endcase
            end
            default: step = mk_wr(A_RES, res_val, 1'b1);
        endcase
    end

endmodule

// File: rtl/lcd_power_seq.sv
module lcd_power_seq
    import lcdseq_pkg::*;
#(
    parameter int MODE_W       = 10,
    parameter int T_RAIL_CYC   = 3000,
    parameter int T_GATE_CYC   = 2000,
    parameter int T_SETTLE_CYC = 1000,
    parameter int T_FRAME_CYC  = 34000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [MODE_W-1:0] up_mode,
    input  logic [7:0]        phase_cal,
    input  logic [8:0]        bias_cal,
    input  logic              down_req,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [7:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              ser_valid,
    input  logic              ser_ready,
    output logic [7:0]        ser_base,
    output logic [7:0]        ser_level,
    output logic              busy,
    output logic              done,
    output logic              inited
);

    localparam int T_MAX_A = (T_RAIL_CYC > T_GATE_CYC) ? T_RAIL_CYC : T_GATE_CYC;
    localparam int T_MAX_B = (T_SETTLE_CYC > T_FRAME_CYC) ? T_SETTLE_CYC : T_FRAME_CYC;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] LIM_RAIL   = CNT_W'(T_RAIL_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_GATE   = CNT_W'(T_GATE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(T_SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_FRAME  = CNT_W'(T_FRAME_CYC - 1);

    typedef struct packed {
        logic              run;
        seq_e              seq;
        logic [4:0]        idx;
        logic [CNT_W-1:0]  cnt;
        logic              pend_up;
        logic              pend_dn;
        logic [MODE_W-1:0] pmode;
        logic [7:0]        pph;
        logic [8:0]        pbi;
        logic [MODE_W-1:0] amode;
        logic [7:0]        aph;
        logic [8:0]        abi;
        logic              busy;
        logic              done;
        logic              inited;
    } state_t;

    state_t st_d, st_q;

    step_t      step;
    logic [7:0] phase_val;
    logic [7:0] res_val;
    logic [7:0] bias_val;
    logic [CNT_W-1:0] lim;
    logic       take;

    lcdseq_cal #(.MODE_W(MODE_W)) u_cal (
        .mode      (st_q.amode),
        .phase_cal (st_q.aph),
        .bias_cal  (st_q.abi),
        .phase_val (phase_val),
        .res_val   (res_val),
        .bias_val  (bias_val)
    );

    lcdseq_rom u_rom (
        .seq       (st_q.seq),
        .idx       (st_q.idx),
        .phase_val (phase_val),
        .res_val   (res_val),
        .bias_val  (bias_val),
        .step      (step)
    );

    always_comb begin
        unique case (step.dly)
            DL_RAIL:   lim = LIM_RAIL;
            DL_GATE:   lim = LIM_GATE;
            DL_SETTLE: lim = LIM_SETTLE;
            default:   lim = LIM_FRAME;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        take      = 1'b0;

        if (!st_q.run) begin
            // power-down outranks a pending power-up
            if (st_q.pend_dn) begin
                st_d.run     = 1'b1;
                st_d.seq     = SQ_DOWN;
                st_d.idx     = '0;
                st_d.cnt     = '0;
                st_d.pend_dn = 1'b0;
                st_d.busy    = 1'b1;
            end else if (st_q.pend_up) begin
                st_d.run     = 1'b1;
                st_d.seq     = st_q.inited ? SQ_SHORT : SQ_FULL;
                st_d.idx     = '0;
                st_d.cnt     = '0;
                st_d.pend_up = 1'b0;
                st_d.busy    = 1'b1;
                st_d.amode   = st_q.pmode;
                st_d.aph     = st_q.pph;
                st_d.abi     = st_q.pbi;
            end
        end else begin
            unique case (step.kind)
                ST_WR:   take = wr_ready;
                ST_SER:  take = ser_ready;
                default: begin
                    if (st_q.cnt == lim) begin
                        st_d.idx = st_q.idx + 5'd1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            endcase

            if (take) begin
                if (step.last) begin
                    st_d.run    = 1'b0;
                    st_d.busy   = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.inited = (st_q.seq != SQ_DOWN);
                end else begin
                    st_d.idx = st_q.idx + 5'd1;
                end
            end
        end

        if (up_req) begin
            st_d.pend_up = 1'b1;
            st_d.pmode   = up_mode;
            st_d.pph     = phase_cal;
            st_d.pbi     = bias_cal;
        end
        if (down_req) begin
            st_d.pend_dn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, seq: SQ_FULL, idx: '0, cnt: '0,
                      pend_up: 1'b0, pend_dn: 1'b0,
                      pmode: '0, pph: '0, pbi: '0,
                      amode: '0, aph: '0, abi: '0,
                      busy: 1'b0, done: 1'b0, inited: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid  = st_q.run && (step.kind == ST_WR);
    assign wr_addr   = step.addr;
    assign wr_data   = step.data;
    assign ser_valid = st_q.run && (step.kind == ST_SER);
    assign ser_base  = step.addr;
    assign ser_level = step.data;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign inited    = st_q.inited;

endmodule

// File: rtl/lcd_power_seq_chk.sv
module lcd_power_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       ser_valid,
    input logic       ser_ready,
    input logic [7:0] ser_base,
    input logic [7:0] ser_level,
    input logic       busy,
    input logic       done,
    input logic       inited
);

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_ser_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid && !ser_ready |=> ser_valid && $stable(ser_base) && $stable(ser_level));

    p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && ser_valid));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_xfer_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || ser_valid) |-> busy);

    p_init_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inited) |-> done);

    p_init_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inited) |-> done);

endmodule

bind lcd_power_seq lcd_power_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ser_valid (ser_valid),
    .ser_ready (ser_ready),
    .ser_base  (ser_base),
    .ser_level (ser_level),
    .busy      (busy),
    .done      (done),
    .inited    (inited)
);

// File: tb/lcd_power_seq_tb.sv
module lcd_power_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TR = 30;
    localparam int TG = 20;
    localparam int TS = 10;
    localparam int TF = 40;

    typedef struct packed {
        logic [9:0] mode;
        logic [7:0] ph;
        logic [8:0] bi;
        logic       stall;
        logic [7:0] e_ph;
        logic [7:0] e_res;
        logic [7:0] e_bi;
    } vec_t;

    localparam vec_t ROWS [6] = '{
        '{10'd640, 8'h05, 9'd200,  1'b0, 8'h0B, 8'h00, 8'd200},
        '{10'd480, 8'hFF, 9'h1FF,  1'b1, 8'h01, 8'h00, 8'd125},
        '{10'd320, 8'h3A, 9'd0,    1'b0, 8'h13, 8'h01, 8'd0},
        '{10'd240, 8'h1F, 9'h1FB,  1'b1, 8'h13, 8'h01, 8'd125},
        '{10'd640, 8'h2C, 9'd255,  1'b0, 8'h19, 8'h00, 8'd255},
        '{10'd100, 8'h07, 9'd1,    1'b1, 8'h13, 8'h01, 8'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_req = 1'b0;
    logic [9:0] up_mode = '0;
    logic [7:0] phase_cal = '0;
    logic [8:0] bias_cal = '0;
    logic       down_req = 1'b0;
    logic       wr_ready = 1'b1;
    logic       ser_ready = 1'b1;
    logic       wr_valid, ser_valid, busy, done, inited;
    logic [7:0] wr_addr, wr_data, ser_base, ser_level;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int done_cnt = 0;
    int req_cyc = 0;
    logic stall = 1'b0;

    logic [7:0] lg_a [64];
    logic [7:0] lg_d [64];
    logic       lg_s [64];
    int         lg_c [64];
    int         lg_n = 0;
    logic [7:0] ex_a [64];
    logic [7:0] ex_d [64];
    logic       ex_s [64];
    int         ex_n = 0;

    lcd_power_seq #(
        .MODE_W(10), .T_RAIL_CYC(TR), .T_GATE_CYC(TG),
        .T_SETTLE_CYC(TS), .T_FRAME_CYC(TF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_mode(up_mode),
        .phase_cal(phase_cal), .bias_cal(bias_cal), .down_req(down_req),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_base(ser_base),
        .ser_level(ser_level), .busy(busy), .done(done), .inited(inited)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc++;

    // ready drive first, then log the transfer the next edge will take
    always @(negedge clk) begin
        wr_ready  = stall ? ~wr_ready : 1'b1;
        ser_ready = wr_ready;
        if (rst_n) begin
            if ((wr_valid && wr_ready) || (ser_valid && ser_ready)) begin
                if (lg_n < 64) begin
                    lg_s[lg_n] = ser_valid;
                    lg_a[lg_n] = ser_valid ? ser_base : wr_addr;
                    lg_d[lg_n] = ser_valid ? ser_level : wr_data;
                    lg_c[lg_n] = cyc;
                end
                lg_n++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] a, input logic [7:0] d, input logic s);
        ex_a[ex_n] = a; ex_d[ex_n] = d; ex_s[ex_n] = s; ex_n++;
    endtask

    task automatic build_full(input logic [7:0] ph, input logic [7:0] res, input logic [7:0] bi);
        add(8'h06, 8'h1F, 0); add(8'h03, 8'h03, 0); add(8'h04, 8'h00, 0);
        add(8'h04, 8'h04, 0); add(8'h03, 8'h07, 0); add(8'h06, 8'h09, 0);
        add(8'h04, bi, 1);    add(8'h03, 8'h17, 0); add(8'h04, 8'h06, 0);
        add(8'h06, 8'h01, 0); add(8'h03, 8'h1F, 0); add(8'h04, 8'h07, 0);
        add(8'h06, 8'h00, 0); add(8'h01, ph, 0);    add(8'h07, 8'h00, 0);
        add(8'h00, res, 0);
    endtask

    task automatic build_down();
        add(8'h04, 8'h06, 0); add(8'h06, 8'h08, 0); add(8'h03, 8'h14, 0);
        add(8'h14, 8'h00, 1); add(8'h04, 8'h04, 0); add(8'h03, 8'h04, 0);
        add(8'h06, 8'h1E, 0); add(8'h03, 8'h00, 0); add(8'h04, 8'h00, 0);
    endtask

    task automatic clear_logs();
        lg_n = 0; ex_n = 0;
    endtask

    task automatic compare(input string req);
        chk(lg_n == ex_n, req, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(lg_a[i] == ex_a[i] && lg_d[i] == ex_d[i] && lg_s[i] == ex_s[i], req,
                int'({lg_s[i], lg_a[i], lg_d[i]}), int'({ex_s[i], ex_a[i], ex_d[i]}));
        end
    endtask

    task automatic pulse(input logic up, input logic dn, input logic [9:0] m,
                         input logic [7:0] p, input logic [8:0] b);
        @(negedge clk);
        up_req = up; down_req = dn; up_mode = m; phase_cal = p; bias_cal = b;
        req_cyc = cyc;
        @(negedge clk);
        up_req = 1'b0; down_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after request", busy, 1);
    endtask

    task automatic wait_done(input int tgt);
        while (done_cnt < tgt) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int tgt;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !inited, "R11 status at reset", {busy, done, inited}, 0);
        chk(!wr_valid && !ser_valid, "R11 valids at reset", {wr_valid, ser_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !wr_valid && !ser_valid, "R11 idle after reset", {busy, wr_valid, ser_valid}, 0);

        for (int r = 0; r < 6; r++) begin
            stall = ROWS[r].stall;
            if (inited) begin
                clear_logs(); build_down();
                tgt = done_cnt + 1;
                pulse(1'b0, 1'b1, '0, '0, '0);
                wait_done(tgt);
                compare("R6 power-down order");
                chk(lg_c[0] - req_cyc >= TF, "R7 frame pause", lg_c[0] - req_cyc, TF);
                @(negedge clk);
                chk(inited == 1'b0, "R6 inited cleared", inited, 0);
            end
            clear_logs();
            build_full(ROWS[r].e_ph, ROWS[r].e_res, ROWS[r].e_bi);
            tgt = done_cnt + 1;
            pulse(1'b1, 1'b0, ROWS[r].mode, ROWS[r].ph, ROWS[r].bi);
            wait_done(tgt);
            compare("R1 power-up order");
            chk(lg_d[6] == ROWS[r].e_bi, "R2 bias level", lg_d[6], ROWS[r].e_bi);
            chk(lg_d[13] == ROWS[r].e_ph, "R3 phase byte", lg_d[13], ROWS[r].e_ph);
            chk(lg_a[15] == 8'h00 && lg_d[15] == ROWS[r].e_res && lg_n == 16,
                "R4 resolution last", lg_d[15], ROWS[r].e_res);
            chk(lg_c[4] - lg_c[3] >= TR, "R7 rail pause", lg_c[4] - lg_c[3], TR);
            chk(lg_c[9] - lg_c[8] >= TG, "R7 gate pause", lg_c[9] - lg_c[8], TG);
            chk(lg_c[15] - lg_c[14] >= TS, "R7 settle pause", lg_c[15] - lg_c[14], TS);
            @(negedge clk);
            chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
            chk(inited == 1'b1, "R5 inited set", inited, 1);

            clear_logs();
            add(8'h01, ROWS[r].e_ph, 0); add(8'h00, ROWS[r].e_res, 0);
            tgt = done_cnt + 1;
            pulse(1'b1, 1'b0, ROWS[r].mode, ROWS[r].ph, ROWS[r].bi);
            wait_done(tgt);
            compare("R5 re-entry writes");
        end

        // R10: power-up arrives in the middle of a power-down
        stall = 1'b0;
        clear_logs(); build_down(); build_full(8'h07, 8'h00, 8'd50);
        tgt = done_cnt + 2;
        pulse(1'b0, 1'b1, '0, '0, '0);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b0, 10'd640, 8'h03, 9'd50);
        wait_done(tgt);
        compare("R10 held request");
        @(negedge clk);
        chk(inited == 1'b1, "R10 inited after held up", inited, 1);

        // R10: both requests in one cycle, power-down first
        clear_logs(); build_down(); build_full(8'h13, 8'h01, 8'd77);
        tgt = done_cnt + 2;
        pulse(1'b1, 1'b1, 10'd320, 8'h00, 9'd77);
        wait_done(tgt);
        compare("R10 down before up");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule